// File: doc/BRIEF.md
# Triggered PWM Timer

This block generates a fixed-period pulse-width-modulated waveform whose high time comes from a reload value. It stays idle until an enable level (`run_i`) is high and a single-cycle trigger pulse arrives. The trigger normally comes from another timer's overflow. From that edge the output goes high and a down-counting period runs for 2^CNT_W-1 count-source ticks. The output stays high for as many ticks as the reload value. Each completed period reloads the counters and starts the next one, with no new trigger needed.

The count source is one of four clock enables, chosen by a 2-bit select. Three are prescaled copies of the system clock. The fourth is an external slow-clock enable, divided down further. A sticky interrupt-request flag is raised on every falling edge of the output. For the two degenerate duty values (all zeros and all ones) it is raised once per period instead. Software clears the flag with a strobe, and an interrupt acknowledge also clears it.

Top module: `trig_pwm_timer`

## Requirements
- R1: `src_sel_i` chooses the count tick. 0 gives every clock cycle, 1 gives one tick per DIV_MID cycles (default 8), 2 gives one tick per DIV_LOW cycles (default 32), and 3 gives one tick per SLOW_DIV pulses of `slow_tick_i` (default 32).
- R2: The block starts only when `trig_i` is high at a clock edge while `run_i` is high and the block is idle. `pwm_o` is high in the cycle after that edge. A trigger while `run_i` is low is ignored. A trigger while the block is already running is also ignored.
- R3: For a reload value n with 0 < n < 2^CNT_W-1, `pwm_o` stays high for exactly n count ticks of each period and then goes low.
- R4: Each period lasts 2^CNT_W-1 count ticks. The next period begins at once without a trigger, using the reload value.
- R5: `reload_i` is sampled only at a start and at period boundaries. A change during a period does not alter that period's high time.
- R6: With `run_i` low at a clock edge, `pwm_o` is low from the next cycle on and counting stops. Raising `run_i` again does not restart the output until a fresh trigger arrives, and that trigger begins a full new period.
- R7: A reload value of 0 keeps `pwm_o` low for the whole period. `irq_o` is still set once at every period boundary.
- R8: A reload value of all ones keeps `pwm_o` high for the whole period. `irq_o` is still set once at every period boundary.
- R9: `irq_o` is set by each high-to-low transition of `pwm_o`. It holds until `irq_clr_i` or `irq_ack_i` is high at an edge. If a set event and a clear fall at the same edge, the set wins.
- R10: After reset, `pwm_o` and `irq_o` are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 2 | Count-source select |
| slow_tick_i | input | 1 | External slow-clock enable pulse |
| run_i | input | 1 | Software start flag (level) |
| trig_i | input | 1 | Overflow trigger pulse |
| reload_i | input | CNT_W | High-time reload value |
| irq_clr_i | input | 1 | Software clear of the request flag |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears the flag |
| pwm_o | output | 1 | PWM output level |
| irq_o | output | 1 | Sticky interrupt request |

## Verification
The request flag can receive a set event, from the output falling, and a clear strobe at the same clock edge. The bench starts a short pulse with a known high time. It then drives the clear strobe exactly at the edge where the counter reaches the end of the high phase. At the next falling clock edge it expects the output low and the flag still high. A following acknowledge pulse on its own must then clear the flag.

// File: rtl/trpwm_pkg.sv
package trpwm_pkg;
   localparam int NUM_SRC = 4;

   typedef enum logic [1:0] {
      SRC_FAST = 2'd0,
      SRC_MID  = 2'd1,
      SRC_LOW  = 2'd2,
      SRC_SLOW = 2'd3
   } src_sel_e;
endpackage

// File: rtl/trpwm_div.sv
module trpwm_div #(
   parameter int DIV = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en_i,
   output logic tick_o
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   if (DIV < 1) begin : g_bad_div
      $error("trpwm_div: DIV must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (en_i) begin
         if (cnt_q == LAST) cnt_q <= '0;
         else               cnt_q <= cnt_q + CW'(1);
      end
   end

   assign tick_o = en_i && (cnt_q == LAST);

   if (DIV > 1) begin : g_chk
      assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
         tick_o |=> !tick_o);
   end
endmodule

// File: rtl/trpwm_prescale.sv
module trpwm_prescale
   import trpwm_pkg::*;
#(
   parameter int DIV_MID  = 8,
   parameter int DIV_LOW  = 32,
   parameter int SLOW_DIV = 32
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sel_i,
   input  logic       slow_i,
   output logic       tick_o
);
   logic [NUM_SRC-1:0] lane_tick;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_lane
      localparam int LDIV = (i == int'(SRC_FAST)) ? 1 :
                            (i == int'(SRC_MID))  ? DIV_MID :
                            (i == int'(SRC_LOW))  ? DIV_LOW : SLOW_DIV;
      logic lane_en;
      if (i == int'(SRC_SLOW)) begin : g_ext
         assign lane_en = slow_i;
      end else begin : g_int
         assign lane_en = 1'b1;
      end
      trpwm_div #(.DIV(LDIV)) u_div (
         .clk    (clk),
         .rst_n  (rst_n),
         .en_i   (lane_en),
         .tick_o (lane_tick[i])
      );
   end

   assign tick_o = lane_tick[sel_i];
endmodule

// File: rtl/trpwm_core.sv
module trpwm_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick_i,
   input  logic         run_i,
   input  logic         trig_i,
   input  logic [W-1:0] reload_i,
   input  logic         clr_i,
   input  logic         ack_i,
   output logic         pwm_o,
   output logic         irq_o
);
   localparam logic [W-1:0] PER_LAST = {{(W-1){1'b1}}, 1'b0};
   localparam logic [W-1:0] ONE      = W'(1);

   logic         active_q;
   logic [W-1:0] per_q;
   logic [W-1:0] hi_q;
   logic         zero_q;
   logic         irq_q;
   logic         start, step, fall_evt;

   assign start    = run_i && trig_i && !active_q;
   assign step     = run_i && active_q && tick_i;
   assign fall_evt = step && ((hi_q == ONE) || ((per_q == '0) && zero_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         per_q    <= '0;
         hi_q     <= '0;
         zero_q   <= 1'b0;
      end else if (!run_i) begin
         active_q <= 1'b0;
      end else if (start) begin
         active_q <= 1'b1;
         per_q    <= PER_LAST;
         hi_q     <= reload_i;
         zero_q   <= (reload_i == '0);
      end else if (step) begin
         if (per_q == '0) begin
            per_q  <= PER_LAST;
            hi_q   <= reload_i;
            zero_q <= (reload_i == '0);
         end else begin
            per_q <= per_q - ONE;
            if (hi_q != '0) hi_q <= hi_q - ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              irq_q <= 1'b0;
      else if (fall_evt)       irq_q <= 1'b1;
      else if (clr_i || ack_i) irq_q <= 1'b0;
   end

   assign pwm_o = active_q && (hi_q != '0);
   assign irq_o = irq_q;

   assert_stop_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> !pwm_o);
   assert_idle_needs_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !(run_i && trig_i)) |=> !pwm_o);
   assert_level_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && run_i && !tick_i) |=> $stable(pwm_o));
   assert_zero_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && zero_q) |-> !pwm_o);
   assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !clr_i && !ack_i) |=> irq_o);
   assert_irq_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt |=> irq_o);
   assert_irq_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((clr_i || ack_i) && !fall_evt) |=> !irq_o);
endmodule

// File: rtl/trig_pwm_timer.sv
module trig_pwm_timer #(
   parameter int CNT_W    = 16,
   parameter int DIV_MID  = 8,
   parameter int DIV_LOW  = 32,
   parameter int SLOW_DIV = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       src_sel_i,
   input  logic             slow_tick_i,
   input  logic             run_i,
   input  logic             trig_i,
   input  logic [CNT_W-1:0] reload_i,
   input  logic             irq_clr_i,
   input  logic             irq_ack_i,
   output logic             pwm_o,
   output logic             irq_o
);
   if (CNT_W < 4) begin : g_bad_width
      $error("trig_pwm_timer: CNT_W must be at least 4");
   end

   logic cnt_tick;

   trpwm_prescale #(
      .DIV_MID  (DIV_MID),
      .DIV_LOW  (DIV_LOW),
      .SLOW_DIV (SLOW_DIV)
   ) u_prescale (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (src_sel_i),
      .slow_i (slow_tick_i),
      .tick_o (cnt_tick)
   );

   trpwm_core #(.W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (cnt_tick),
      .run_i    (run_i),
      .trig_i   (trig_i),
      .reload_i (reload_i),
      .clr_i    (irq_clr_i),
      .ack_i    (irq_ack_i),
      .pwm_o    (pwm_o),
      .irq_o    (irq_o)
   );
endmodule

// File: tb/trig_pwm_timer_tb.sv
module trig_pwm_timer_tb_top;
   localparam int W = 8;
   localparam int P = (1 << W) - 1;

   typedef struct packed {
      logic [1:0]  sel;
      logic [7:0]  duty;
      int unsigned hi;
      int unsigned per;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{2'd0, 8'd1,   1,   255},
      '{2'd0, 8'd3,   3,   255},
      '{2'd0, 8'd100, 100, 255},
      '{2'd0, 8'd254, 254, 255},
      '{2'd1, 8'd5,   40,  2040},
      '{2'd2, 8'd2,   64,  8160},
      '{2'd3, 8'd2,   128, 0}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   src_sel_i = '0;
   logic         slow_tick_i = 1'b0;
   logic         run_i = 1'b0;
   logic         trig_i = 1'b0;
   logic [W-1:0] reload_i = '0;
   logic         irq_clr_i = 1'b0;
   logic         irq_ack_i = 1'b0;
   logic         pwm_o, irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   int hi_cnt, lo_cnt, seen;

   always #2.5 clk = ~clk;
   always @(negedge clk) slow_tick_i <= ~slow_tick_i;

   trig_pwm_timer #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_sel_i(src_sel_i), .slow_tick_i(slow_tick_i),
      .run_i(run_i), .trig_i(trig_i), .reload_i(reload_i),
      .irq_clr_i(irq_clr_i), .irq_ack_i(irq_ack_i), .pwm_o(pwm_o), .irq_o(irq_o)
   );

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic fire();
      trig_i = 1'b1; step(1); trig_i = 1'b0;
   endtask

   task automatic clear_irq();
      irq_clr_i = 1'b1; step(1); irq_clr_i = 1'b0;
   endtask

   task automatic halt();
      run_i = 1'b0; step(2);
   endtask

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      chk(pwm_o == 1'b0, "R10 pwm after reset", pwm_o, 0);
      chk(irq_o == 1'b0, "R10 irq after reset", irq_o, 0);

      // R1 R3 R4: vector table
      for (int v = 0; v < NV; v++) begin
         halt();
         src_sel_i = VECS[v].sel;
         reload_i = VECS[v].duty;
         clear_irq();
         run_i = 1'b1;
         fire();
         while (pwm_o) step(1);
         while (!pwm_o) step(1);
         hi_cnt = 0;
         while (pwm_o) begin hi_cnt++; step(1); end
         chk(hi_cnt == int'(VECS[v].hi), $sformatf("R1 R3 high time vec%0d", v), hi_cnt, VECS[v].hi);
         if (VECS[v].per != 0) begin
            lo_cnt = 0;
            while (!pwm_o) begin lo_cnt++; step(1); end
            chk(hi_cnt + lo_cnt == int'(VECS[v].per), $sformatf("R4 period vec%0d", v),
                hi_cnt + lo_cnt, VECS[v].per);
         end
         chk(irq_o == 1'b1, $sformatf("R9 irq after fall vec%0d", v), irq_o, 1);
      end

      // R2: first rise and R9 set/clear collision
      halt();
      src_sel_i = 2'd0;
      reload_i = 8'd3;
      clear_irq();
      run_i = 1'b1;
      step(1);
      chk(pwm_o == 1'b0, "R2 low before trigger", pwm_o, 0);
      fire();
      chk(pwm_o == 1'b1, "R2 high after trigger", pwm_o, 1);
      step(2);
      chk(irq_o == 1'b0, "R9 no irq before fall", irq_o, 0);
      irq_clr_i = 1'b1; step(1); irq_clr_i = 1'b0;
      chk(pwm_o == 1'b0, "R3 fall after 3 ticks", pwm_o, 0);
      chk(irq_o == 1'b1, "R9 set wins over clear", irq_o, 1);
      irq_ack_i = 1'b1; step(1); irq_ack_i = 1'b0;
      chk(irq_o == 1'b0, "R9 ack clears", irq_o, 0);

      // R2: trigger with run low ignored
      halt();
      fire();
      step(5);
      chk(pwm_o == 1'b0, "R2 trigger ignored when stopped", pwm_o, 0);

      // R2: trigger while running ignored
      reload_i = 8'd100;
      run_i = 1'b1;
      fire();
      step(30);
      fire();
      hi_cnt = 31;
      while (pwm_o) begin hi_cnt++; step(1); end
      chk(hi_cnt == 100, "R2 retrigger ignored while running", hi_cnt, 100);

      // R5: reload change mid-period
      halt();
      reload_i = 8'd10;
      run_i = 1'b1;
      fire();
      step(3);
      reload_i = 8'd50;
      hi_cnt = 3;
      while (pwm_o) begin hi_cnt++; step(1); end
      chk(hi_cnt == 10, "R5 current period keeps old value", hi_cnt, 10);
      while (!pwm_o) step(1);
      hi_cnt = 0;
      while (pwm_o) begin hi_cnt++; step(1); end
      chk(hi_cnt == 50, "R5 next period uses new value", hi_cnt, 50);

      // R6: stop, re-arm, restart
      halt();
      reload_i = 8'd200;
      run_i = 1'b1;
      fire();
      step(20);
      run_i = 1'b0;
      step(1);
      chk(pwm_o == 1'b0, "R6 low after stop", pwm_o, 0);
      step(5);
      run_i = 1'b1;
      step(20);
      chk(pwm_o == 1'b0, "R6 waits for fresh trigger", pwm_o, 0);
      fire();
      hi_cnt = 0;
      while (pwm_o) begin hi_cnt++; step(1); end
      chk(hi_cnt == 200, "R6 restart gives full high time", hi_cnt, 200);

      // R7: zero duty
      halt();
      reload_i = 8'd0;
      clear_irq();
      run_i = 1'b1;
      fire();
      for (int k = 0; k < 2; k++) begin
         seen = 0;
         for (int c = 0; c < P + 2; c++) begin
            if (pwm_o) seen++;
            step(1);
         end
         chk(seen == 0, "R7 output stays low", seen, 0);
         chk(irq_o == 1'b1, "R7 irq each period", irq_o, 1);
         clear_irq();
         chk(irq_o == 1'b0, "R7 irq cleared", irq_o, 0);
      end

      // R8: all-ones duty
      halt();
      reload_i = '1;
      clear_irq();
      run_i = 1'b1;
      fire();
      step(100);
      chk(irq_o == 1'b0, "R8 no irq mid-period", irq_o, 0);
      seen = 0;
      for (int c = 0; c < 2 * P; c++) begin
         if (!pwm_o) seen++;
         step(1);
      end
      chk(seen == 0, "R8 output stays high", seen, 0);
      chk(irq_o == 1'b1, "R8 irq at boundary", irq_o, 1);
      clear_irq();
      step(P);
      chk(irq_o == 1'b1, "R8 irq again next period", irq_o, 1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule